// File: doc/BRIEF.md
# Tagged Fully Associative Translation Buffer

This block caches translations from virtual page numbers to physical frame numbers so that a load/store unit can turn a virtual address into a physical address without touching the page tables. Every entry is searched in parallel. The hit, the translated address, a multi-hit flag and a permission abort are all produced combinationally in the same cycle as the request. Each entry carries a region size: 4 KB, 64 KB, 1 MB or 16 MB. Only the virtual bits above that region's offset take part in the compare, and the translated address keeps the request's own offset bits.

Entries belong to one address space, named by an 8-bit tag, and to one security state. An entry may instead be marked global, which makes it match in every address space and both security states. A table-walk engine outside this block writes new entries through the fill port. The victim is always the lowest-index empty slot, if there is one. When every slot is valid, the victim comes either from a rotating pointer or from a free-running pseudo-random register. Maintenance logic can drop every entry, or only the non-global entries of one address space, in a single cycle.

Top module: `tlb_fa`

## Requirements
- R1: After reset every entry is invalid, so any lookup misses and `lk_abort` and `lk_multi` are 0.
- R2: A lookup hits when a valid entry's VPN equals the request VPN (`lk_va[31:12]`) on the bits kept by the entry's size code (0 = 4 KB, all 20 bits; 1 = 64 KB, the upper 16 bits; 2 = 1 MB, the upper 12 bits; 3 = 16 MB, the upper 8 bits). On a hit, `lk_pa` takes the entry's frame bits in those kept positions and `lk_va` in all lower positions. `lk_pa` is 0 when there is no hit. The result appears in the same cycle as the request.
- R3: A non-global entry matches only when both its address-space tag and its security bit equal `lk_asid` and `lk_ns`. A global entry ignores both.
- R4: Permission fields are 2-bit levels: 0 = no access, 1 = read-only, 2 or 3 = read/write. The privileged field applies when `lk_priv` = 1 and the user field otherwise. `lk_abort` is 1 on a hit whose level is 0, or whose level is 1 while `lk_write` = 1, or when `lk_exec` = 1 and the entry's execute-never bit is set. A miss never aborts.
- R5: When several entries match, the lowest-index one supplies `lk_pa` and the permission check, and `lk_multi` is 1.
- R6: A fill writes the lowest-index invalid entry when one exists, in either victim mode.
- R7: With `victim_rand` = 0 and all entries valid, a fill replaces the entry named by a rotating pointer. The pointer starts at 0 after reset and advances by one, modulo the entry count, on each such replacement only.
- R8: With `victim_rand` = 1 and all entries valid, a fill replaces exactly one existing entry, chosen by a free-running LFSR.
- R9: `flush_all` invalidates every entry at the next clock edge.
- R10: `flush_asid_en` invalidates every non-global entry whose tag equals `flush_asid`, whatever its security bit. Global entries and entries of other tags are kept.
- R11: A fill presented in the same cycle as either flush command is discarded.
- R12: With `lk_req` = 0, `lk_hit`, `lk_abort`, `lk_multi` and `lk_pa` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request qualifier |
| lk_va | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Current address-space tag |
| lk_ns | input | 1 | Current security state (1 = non-secure) |
| lk_priv | input | 1 | Request is privileged |
| lk_write | input | 1 | Request is a write |
| lk_exec | input | 1 | Request is an instruction fetch |
| lk_hit | output | 1 | Translation found |
| lk_pa | output | 32 | Translated physical address |
| lk_abort | output | 1 | Permission fault on the hitting entry |
| lk_multi | output | 1 | More than one entry matched |
| fill_en | input | 1 | Write a new entry this cycle |
| fill_vpn | input | 20 | Virtual page number of the new entry |
| fill_pfn | input | 20 | Physical frame number of the new entry |
| fill_size | input | 2 | Region size code of the new entry |
| fill_asid | input | 8 | Address-space tag of the new entry |
| fill_ns | input | 1 | Security bit of the new entry |
| fill_global | input | 1 | New entry matches in all address spaces |
| fill_pperm | input | 2 | Privileged access level |
| fill_uperm | input | 2 | User access level |
| fill_xn | input | 1 | Execute-never |
| flush_all | input | 1 | Invalidate all entries |
| flush_asid_en | input | 1 | Invalidate the non-global entries of one tag |
| flush_asid | input | 8 | Tag for the selective flush |
| victim_rand | input | 1 | 0 = rotating victim, 1 = LFSR victim |

## Verification
Directed lookups place requests just inside and just outside each region size, which separates correct masking from compares that use too many or too few bits. Other directed lookups change only the address-space tag, only the security bit, or only the global flag, and walk every permission level against reads, writes and fetches in both modes. Duplicate fills are used to show which entry wins: one placed into a slot freed by a selective flush shows that invalid slots are filled first, and others show the lowest-index priority on a multi-hit. A long run of random fills, flushes and lookups draws from a small address and tag pool, so that the table fills, wraps the rotating pointer and meets overlapping regions. Every lookup in that run is compared against a reference table kept by the bench.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    // Each size step widens the page offset by this many VPN bits.
    localparam int SZ_STEP = 4;

    typedef enum logic [1:0] {
        PG_4K  = 2'd0,
        PG_64K = 2'd1,
        PG_1M  = 2'd2,
        PG_16M = 2'd3
    } pg_size_e;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_RO   = 2'd1,
        ACC_RW   = 2'd2,
        ACC_RW_B = 2'd3
    } acc_lvl_e;

    typedef enum logic {
        VICT_RR   = 1'b0,
        VICT_LFSR = 1'b1
    } vict_mode_e;

endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int VPN_W  = 20,
    parameter int ASID_W = 8
) (
    input  logic              ent_vld,
    input  logic              ent_glb,
    input  logic              ent_ns,
    input  logic [ASID_W-1:0] ent_asid,
    input  logic [VPN_W-1:0]  ent_vpn,
    input  pg_size_e          ent_sz,
    input  logic [VPN_W-1:0]  req_vpn,
    input  logic [ASID_W-1:0] req_asid,
    input  logic              req_ns,
    output logic              hit
);

    logic [VPN_W-1:0] keep_mask;
    logic             addr_eq;
    logic             ctx_eq;

    always_comb begin
        keep_mask = {VPN_W{1'b1}} << (32'(ent_sz) * SZ_STEP);
        addr_eq   = ((ent_vpn ^ req_vpn) & keep_mask) == '0;
        ctx_eq    = ent_glb || ((ent_asid == req_asid) && (ent_ns == req_ns));
        hit       = ent_vld && addr_eq && ctx_eq;
    end

endmodule

// File: rtl/tlb_sel.sv
module tlb_sel #(
    parameter int ENTRIES = 32,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0] match,
    output logic [IDX_W-1:0]   first_idx,
    output logic               any_hit,
    output logic               many_hit
);

    always_comb begin
        first_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                first_idx = IDX_W'(i);
            end
        end
        any_hit  = |match;
        many_hit = |(match & (match - ENTRIES'(1)));
    end

endmodule

// File: rtl/tlb_perm.sv
module tlb_perm
    import tlb_pkg::*;
(
    input  logic [1:0] priv_lvl,
    input  logic [1:0] user_lvl,
    input  logic       xn,
    input  logic       is_priv,
    input  logic       is_write,
    input  logic       is_exec,
    output logic       deny
);

    acc_lvl_e lvl;
    logic     fetch_blk;

    always_comb begin
        lvl       = acc_lvl_e'(is_priv ? priv_lvl : user_lvl);
        fetch_blk = is_exec && xn;
        unique case (lvl)
            ACC_NONE: deny = 1'b1;
            ACC_RO:   deny = is_write || fetch_blk;
            ACC_RW:   deny = fetch_blk;
            ACC_RW_B: deny = fetch_blk;
            default:  deny = 1'b1;
        endcase
    end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
    import tlb_pkg::*;
#(
    parameter int          ENTRIES   = 32,
    parameter int          LFSR_W    = 16,
    parameter logic [15:0] LFSR_TAPS = 16'hB400,
    parameter logic [15:0] LFSR_SEED = 16'hACE1,
    localparam int         IDX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid,
    input  vict_mode_e         mode,
    input  logic               write_en,
    output logic [IDX_W-1:0]   victim
);

    logic [IDX_W-1:0]  rr_q;
    logic [LFSR_W-1:0] lfsr_q;
    logic [IDX_W-1:0]  free_idx;
    logic              have_free;
    logic [IDX_W-1:0]  rand_idx;

    always_comb begin
        free_idx  = '0;
        have_free = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                free_idx  = IDX_W'(i);
                have_free = 1'b1;
            end
        end
    end

    assign rand_idx = IDX_W'(lfsr_q % LFSR_W'(ENTRIES));

    always_comb begin
        if (have_free) begin
            victim = free_idx;
        end else begin
            unique case (mode)
                VICT_RR:   victim = rr_q;
                VICT_LFSR: victim = rand_idx;
                default:   victim = rr_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (write_en && !have_free && mode == VICT_RR) begin
            rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr_q <= LFSR_W'(LFSR_SEED);
        end else begin
            lfsr_q <= (lfsr_q >> 1) ^ (lfsr_q[0] ? LFSR_W'(LFSR_TAPS) : '0);
        end
    end

endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
    import tlb_pkg::*;
#(
    parameter int ENTRIES  = 32,
    parameter int ASID_W   = 8,
    parameter int VA_W     = 32,
    parameter int PA_W     = 32,
    parameter int PG_SHIFT = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     lk_req,
    input  logic [VA_W-1:0]          lk_va,
    input  logic [ASID_W-1:0]        lk_asid,
    input  logic                     lk_ns,
    input  logic                     lk_priv,
    input  logic                     lk_write,
    input  logic                     lk_exec,
    output logic                     lk_hit,
    output logic [PA_W-1:0]          lk_pa,
    output logic                     lk_abort,
    output logic                     lk_multi,
    input  logic                     fill_en,
    input  logic [VA_W-PG_SHIFT-1:0] fill_vpn,
    input  logic [PA_W-PG_SHIFT-1:0] fill_pfn,
    input  logic [1:0]               fill_size,
    input  logic [ASID_W-1:0]        fill_asid,
    input  logic                     fill_ns,
    input  logic                     fill_global,
    input  logic [1:0]               fill_pperm,
    input  logic [1:0]               fill_uperm,
    input  logic                     fill_xn,
    input  logic                     flush_all,
    input  logic                     flush_asid_en,
    input  logic [ASID_W-1:0]        flush_asid,
    input  logic                     victim_rand
);

    localparam int VPN_W = VA_W - PG_SHIFT;
    localparam int PFN_W = PA_W - PG_SHIFT;
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    // Entry storage
    logic [ENTRIES-1:0] ent_v;
    logic [ENTRIES-1:0] ent_g;
    logic [ENTRIES-1:0] ent_ns;
    logic [ENTRIES-1:0] ent_xn;
    logic [ASID_W-1:0]  ent_asid [ENTRIES];
    logic [VPN_W-1:0]   ent_vpn  [ENTRIES];
    logic [PFN_W-1:0]   ent_pfn  [ENTRIES];
    pg_size_e           ent_sz   [ENTRIES];
    logic [1:0]         ent_pp   [ENTRIES];
    logic [1:0]         ent_up   [ENTRIES];

    logic [VPN_W-1:0]   lk_vpn;
    logic [ENTRIES-1:0] match;
    logic [IDX_W-1:0]   sel_idx;
    logic               any_hit;
    logic               many_hit;
    logic               deny;
    logic [IDX_W-1:0]   victim_idx;
    logic               fill_fire;
    vict_mode_e         vmode;
    logic [PFN_W-1:0]   keep_mask;
    logic [PFN_W-1:0]   frame;

    assign lk_vpn    = lk_va[VA_W-1:PG_SHIFT];
    assign fill_fire = fill_en && !flush_all && !flush_asid_en;
    assign vmode     = vict_mode_e'(victim_rand);

    // Parallel compare, one comparator per entry
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        tlb_match #(
            .VPN_W  (VPN_W),
            .ASID_W (ASID_W)
        ) u_match (
            .ent_vld  (ent_v[g]),
            .ent_glb  (ent_g[g]),
            .ent_ns   (ent_ns[g]),
            .ent_asid (ent_asid[g]),
            .ent_vpn  (ent_vpn[g]),
            .ent_sz   (ent_sz[g]),
            .req_vpn  (lk_vpn),
            .req_asid (lk_asid),
            .req_ns   (lk_ns),
            .hit      (match[g])
        );
    end

    tlb_sel #(
        .ENTRIES (ENTRIES)
    ) u_sel (
        .match     (match),
        .first_idx (sel_idx),
        .any_hit   (any_hit),
        .many_hit  (many_hit)
    );

    tlb_perm u_perm (
        .priv_lvl (ent_pp[sel_idx]),
        .user_lvl (ent_up[sel_idx]),
        .xn       (ent_xn[sel_idx]),
        .is_priv  (lk_priv),
        .is_write (lk_write),
        .is_exec  (lk_exec),
        .deny     (deny)
    );

    tlb_victim #(
        .ENTRIES (ENTRIES)
    ) u_victim (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (ent_v),
        .mode     (vmode),
        .write_en (fill_fire),
        .victim   (victim_idx)
    );

    // Translated address: frame bits above the region offset, request bits below
    always_comb begin
        keep_mask = {PFN_W{1'b1}} << (32'(ent_sz[sel_idx]) * SZ_STEP);
        frame     = (ent_pfn[sel_idx] & keep_mask) | (PFN_W'(lk_vpn) & ~keep_mask);
        lk_hit    = lk_req && any_hit;
        lk_multi  = lk_req && many_hit;
        lk_abort  = lk_hit && deny;
        lk_pa     = lk_hit ? {frame, lk_va[PG_SHIFT-1:0]} : '0;
    end

    // Valid bits: flush commands first, then fill
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_v <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (flush_all) begin
                    ent_v[i] <= 1'b0;
                end else if (flush_asid_en && !ent_g[i] && ent_asid[i] == flush_asid) begin
                    ent_v[i] <= 1'b0;
                end else if (fill_fire && victim_idx == IDX_W'(i)) begin
                    ent_v[i] <= 1'b1;
                end
            end
        end
    end

    // Entry payload
    always_ff @(posedge clk) begin
        if (fill_fire) begin
            ent_g[victim_idx]    <= fill_global;
            ent_ns[victim_idx]   <= fill_ns;
            ent_xn[victim_idx]   <= fill_xn;
            ent_asid[victim_idx] <= fill_asid;
            ent_vpn[victim_idx]  <= fill_vpn;
            ent_pfn[victim_idx]  <= fill_pfn;
            ent_sz[victim_idx]   <= pg_size_e'(fill_size);
            ent_pp[victim_idx]   <= fill_pperm;
            ent_up[victim_idx]   <= fill_uperm;
        end
    end

endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk #(
    parameter int ENTRIES = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_req,
    input logic               lk_hit,
    input logic               lk_abort,
    input logic               lk_multi,
    input logic               fill_en,
    input logic               flush_all,
    input logic               flush_asid_en,
    input logic [ENTRIES-1:0] ent_v
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |-> (!lk_hit && !lk_abort && !lk_multi)); // R12

    AST_ABORT_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_abort |-> lk_hit); // R4

    AST_MULTI_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_multi |-> lk_hit); // R5

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (ent_v == '0)); // R9

    AST_FLUSH_BLOCKS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_all || flush_asid_en) |=> ($countones(ent_v) <= $past($countones(ent_v)))); // R11

    AST_FREE_SLOT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flush_all && !flush_asid_en && !(&ent_v))
            |=> ($countones(ent_v) == $past($countones(ent_v)) + 1)); // R6

    AST_NO_SILENT_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_all && !flush_asid_en) |=> ($countones(ent_v) >= $past($countones(ent_v)))); // R7

endmodule

bind tlb_fa tlb_fa_chk #(
    .ENTRIES (ENTRIES)
) u_tlb_fa_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .lk_req        (lk_req),
    .lk_hit        (lk_hit),
    .lk_abort      (lk_abort),
    .lk_multi      (lk_multi),
    .fill_en       (fill_en),
    .flush_all     (flush_all),
    .flush_asid_en (flush_asid_en),
    .ent_v         (ent_v)
);

// File: tb/tb_tlb_fa.sv
`timescale 1ns/1ps
module tb_tlb_fa;

    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0;
    logic [31:0] lk_va = '0;
    logic [7:0]  lk_asid = '0;
    logic        lk_ns = 1'b0;
    logic        lk_priv = 1'b0;
    logic        lk_write = 1'b0;
    logic        lk_exec = 1'b0;
    logic        lk_hit;
    logic [31:0] lk_pa;
    logic        lk_abort;
    logic        lk_multi;
    logic        fill_en = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_pfn = '0;
    logic [1:0]  fill_size = '0;
    logic [7:0]  fill_asid = '0;
    logic        fill_ns = 1'b0;
    logic        fill_global = 1'b0;
    logic [1:0]  fill_pperm = '0;
    logic [1:0]  fill_uperm = '0;
    logic        fill_xn = 1'b0;
    logic        flush_all = 1'b0;
    logic        flush_asid_en = 1'b0;
    logic [7:0]  flush_asid = '0;
    logic        victim_rand = 1'b0;

    always #5 clk = ~clk;

    tlb_fa dut (
        .clk(clk), .rst_n(rst_n),
        .lk_req(lk_req), .lk_va(lk_va), .lk_asid(lk_asid), .lk_ns(lk_ns),
        .lk_priv(lk_priv), .lk_write(lk_write), .lk_exec(lk_exec),
        .lk_hit(lk_hit), .lk_pa(lk_pa), .lk_abort(lk_abort), .lk_multi(lk_multi),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
        .fill_size(fill_size), .fill_asid(fill_asid), .fill_ns(fill_ns),
        .fill_global(fill_global), .fill_pperm(fill_pperm), .fill_uperm(fill_uperm),
        .fill_xn(fill_xn), .flush_all(flush_all), .flush_asid_en(flush_asid_en),
        .flush_asid(flush_asid), .victim_rand(victim_rand)
    );

    // Reference table built from the requirements
    logic        m_v    [N];
    logic        m_g    [N];
    logic        m_ns   [N];
    logic        m_xn   [N];
    logic [7:0]  m_asid [N];
    logic [19:0] m_vpn  [N];
    logic [19:0] m_pfn  [N];
    logic [1:0]  m_sz   [N];
    logic [1:0]  m_pp   [N];
    logic [1:0]  m_up   [N];
    int          m_rr;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    function automatic logic [19:0] keep_of(input logic [1:0] sz);
        return 20'hFFFFF << (32'(sz) * 4);
    endfunction

    function automatic logic [34:0] expect_lookup(input logic req, input logic [31:0] va,
            input logic [7:0] asid, input logic ns, input logic priv,
            input logic wr, input logic ex);
        int first = -1;
        int cnt = 0;
        logic [19:0] vpn = va[31:12];
        logic [19:0] km;
        logic [1:0]  lvl;
        logic        ab;
        logic [31:0] pa;
        for (int i = 0; i < N; i++) begin
            if (m_v[i] && (((m_vpn[i] ^ vpn) & keep_of(m_sz[i])) == 20'h0) &&
                (m_g[i] || (m_asid[i] == asid && m_ns[i] == ns))) begin
                cnt++;
                if (first < 0) first = i;
            end
        end
        if (!req || cnt == 0) return '0;
        km  = keep_of(m_sz[first]);
        pa  = {(m_pfn[first] & km) | (vpn & ~km), va[11:0]};
        lvl = priv ? m_pp[first] : m_up[first];
        ab  = (lvl == 2'd0) || (wr && lvl == 2'd1) || (ex && m_xn[first]);
        return {1'b1, (cnt > 1), ab, pa};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [34:0] act, input logic [34:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got hit/multi/abort/pa=%h expected %h", tag, act, exp);
        end
    endtask

    // Model update at the clock edge; returns without change on an unpredictable victim.
    task automatic model_edge();
        int vi = -1;
        if (flush_all) begin
            for (int i = 0; i < N; i++) m_v[i] = 1'b0;
        end else if (flush_asid_en) begin
            for (int i = 0; i < N; i++)
                if (!m_g[i] && m_asid[i] == flush_asid) m_v[i] = 1'b0;
        end else if (fill_en) begin
            for (int i = N - 1; i >= 0; i--) if (!m_v[i]) vi = i;
            if (vi < 0) begin
                if (victim_rand) return;
                vi = m_rr;
                m_rr = (m_rr + 1) % N;
            end
            m_v[vi] = 1'b1;     m_g[vi] = fill_global; m_ns[vi] = fill_ns;
            m_xn[vi] = fill_xn; m_asid[vi] = fill_asid; m_vpn[vi] = fill_vpn;
            m_pfn[vi] = fill_pfn; m_sz[vi] = fill_size; m_pp[vi] = fill_pperm;
            m_up[vi] = fill_uperm;
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        fill_en = 1'b0;
        flush_all = 1'b0;
        flush_asid_en = 1'b0;
    endtask

    task automatic do_fill(input logic [19:0] vpn, input logic [19:0] pfn, input logic [1:0] sz,
            input logic [7:0] asid, input logic ns, input logic g,
            input logic [1:0] pp, input logic [1:0] up, input logic xn);
        fill_en = 1'b1; fill_vpn = vpn; fill_pfn = pfn; fill_size = sz;
        fill_asid = asid; fill_ns = ns; fill_global = g;
        fill_pperm = pp; fill_uperm = up; fill_xn = xn;
        tick();
    endtask

    task automatic do_flush_all();
        flush_all = 1'b1;
        tick();
    endtask

    task automatic do_flush_asid(input logic [7:0] a);
        flush_asid_en = 1'b1;
        flush_asid = a;
        tick();
    endtask

    task automatic probe(input logic req, input logic [31:0] va, input logic [7:0] asid,
            input logic ns, input logic priv, input logic wr, input logic ex, input string tag);
        logic [34:0] exp;
        logic [34:0] act;
        lk_req = req; lk_va = va; lk_asid = asid; lk_ns = ns;
        lk_priv = priv; lk_write = wr; lk_exec = ex;
        #1;
        exp = expect_lookup(req, va, asid, ns, priv, wr, ex);
        act = {lk_hit, lk_multi, lk_abort, lk_pa};
        chk(act === exp, tag, act, exp);
        @(negedge clk);
        lk_req = 1'b0;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, got 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int misses;
        void'($urandom(32'd1177));
        for (int i = 0; i < N; i++) begin
            m_v[i] = 1'b0; m_g[i] = 1'b0; m_ns[i] = 1'b0; m_xn[i] = 1'b0;
            m_asid[i] = '0; m_vpn[i] = '0; m_pfn[i] = '0; m_sz[i] = '0;
            m_pp[i] = '0; m_up[i] = '0;
        end
        m_rr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: empty after reset
        probe(1, 32'h0000_0000, 8'd0, 0, 1, 0, 0, "R1");
        probe(1, 32'h1234_5678, 8'd7, 1, 0, 1, 1, "R1");

        // R2: each region size, inside and outside
        do_fill(20'h10000, 20'h80000, 2'd0, 8'd1, 0, 0, 2'd2, 2'd2, 0);
        do_fill(20'h20010, 20'h81230, 2'd1, 8'd1, 0, 0, 2'd2, 2'd2, 0);
        do_fill(20'h30100, 20'h82400, 2'd2, 8'd1, 0, 0, 2'd2, 2'd2, 0);
        do_fill(20'h41000, 20'h93000, 2'd3, 8'd1, 0, 0, 2'd2, 2'd2, 0);
        probe(1, 32'h1000_0ABC, 8'd1, 0, 1, 0, 0, "R2 4K in");
        probe(1, 32'h1000_1ABC, 8'd1, 0, 1, 0, 0, "R2 4K out");
        probe(1, 32'h2001_F123, 8'd1, 0, 1, 0, 0, "R2 64K in");
        probe(1, 32'h2002_0123, 8'd1, 0, 1, 0, 0, "R2 64K out");
        probe(1, 32'h301F_FFFF, 8'd1, 0, 1, 0, 0, "R2 1M in");
        probe(1, 32'h3020_0000, 8'd1, 0, 1, 0, 0, "R2 1M out");
        probe(1, 32'h41AB_CDEF, 8'd1, 0, 1, 0, 0, "R2 16M in");
        probe(1, 32'h4200_0000, 8'd1, 0, 1, 0, 0, "R2 16M out");

        // R12: no request, no outputs
        probe(0, 32'h1000_0ABC, 8'd1, 0, 1, 0, 0, "R12");

        // R3: tag, security and global
        do_fill(20'h50000, 20'h05000, 2'd0, 8'd5, 0, 0, 2'd2, 2'd2, 0);
        do_fill(20'h60000, 20'h06000, 2'd0, 8'd5, 0, 1, 2'd2, 2'd2, 0);
        probe(1, 32'h5000_0000, 8'd5, 0, 1, 0, 0, "R3 own tag");
        probe(1, 32'h5000_0000, 8'd6, 0, 1, 0, 0, "R3 other tag");
        probe(1, 32'h5000_0000, 8'd5, 1, 1, 0, 0, "R3 other ns");
        probe(1, 32'h6000_0010, 8'd9, 1, 1, 0, 0, "R3 global");

        // R4: every level against read, write and fetch in both modes
        do_fill(20'h70000, 20'h07000, 2'd0, 8'd1, 0, 0, 2'd2, 2'd0, 0);
        do_fill(20'h70001, 20'h07001, 2'd0, 8'd1, 0, 0, 2'd1, 2'd1, 1);
        do_fill(20'h70002, 20'h07002, 2'd0, 8'd1, 0, 0, 2'd0, 2'd3, 0);
        for (int e = 0; e < 3; e++)
            for (int a = 0; a < 8; a++)
                probe(1, {20'h70000 + 20'(e), 12'h010}, 8'd1, 0, a[2], a[1], a[0], "R4");
        probe(1, 32'h7777_7000, 8'd1, 0, 0, 1, 1, "R4 miss no abort");

        // R5: duplicate mapping, lower index wins
        do_fill(20'h70000, 20'h0EEEE, 2'd0, 8'd1, 0, 0, 2'd2, 2'd2, 0);
        probe(1, 32'h7000_0044, 8'd1, 0, 0, 0, 0, "R5");

        // R9 then R6: a freed middle slot is reused before any higher slot
        do_flush_all();
        probe(1, 32'h1000_0ABC, 8'd1, 0, 1, 0, 0, "R9");
        do_fill(20'h11111, 20'h00001, 2'd0, 8'd2, 0, 0, 2'd2, 2'd2, 0);
        do_fill(20'h22222, 20'h00002, 2'd0, 8'd3, 0, 0, 2'd2, 2'd2, 0);
        do_fill(20'h33333, 20'h00003, 2'd0, 8'd2, 0, 0, 2'd2, 2'd2, 0);
        do_flush_asid(8'd3);
        do_fill(20'h33333, 20'h0BEEF, 2'd0, 8'd2, 0, 0, 2'd2, 2'd2, 0);
        probe(1, 32'h3333_3000, 8'd2, 0, 1, 0, 0, "R6");

        // R10: selective flush
        do_fill(20'h44440, 20'h00010, 2'd0, 8'd4, 0, 0, 2'd2, 2'd2, 0);
        do_fill(20'h44441, 20'h00011, 2'd0, 8'd4, 1, 0, 2'd2, 2'd2, 0);
        do_fill(20'h44442, 20'h00012, 2'd0, 8'd4, 0, 1, 2'd2, 2'd2, 0);
        do_fill(20'h44443, 20'h00013, 2'd0, 8'd5, 0, 0, 2'd2, 2'd2, 0);
        do_flush_asid(8'd4);
        probe(1, 32'h4444_0000, 8'd4, 0, 1, 0, 0, "R10 tag ns0");
        probe(1, 32'h4444_1000, 8'd4, 1, 1, 0, 0, "R10 tag ns1");
        probe(1, 32'h4444_2000, 8'd4, 0, 1, 0, 0, "R10 global kept");
        probe(1, 32'h4444_3000, 8'd5, 0, 1, 0, 0, "R10 other kept");

        // R11: fill alongside a flush is dropped
        fill_en = 1'b1; fill_vpn = 20'h55555; fill_pfn = 20'h00055; fill_size = 2'd0;
        fill_asid = 8'd7; fill_ns = 0; fill_global = 0; fill_pperm = 2'd2;
        fill_uperm = 2'd2; fill_xn = 0; flush_all = 1'b1;
        tick();
        probe(1, 32'h5555_5000, 8'd7, 0, 1, 0, 0, "R11 with flush_all");
        fill_en = 1'b1; flush_asid_en = 1'b1; flush_asid = 8'd9;
        tick();
        probe(1, 32'h5555_5000, 8'd7, 0, 1, 0, 0, "R11 with flush_asid");

        // R7: rotating victim once full
        do_flush_all();
        for (int i = 0; i < N; i++)
            do_fill(20'h20000 + 20'(i), 20'h01000 + 20'(i), 2'd0, 8'd1, 0, 0, 2'd2, 2'd2, 0);
        do_fill(20'h2AAAA, 20'h0AAAA, 2'd0, 8'd1, 0, 0, 2'd2, 2'd2, 0);
        do_fill(20'h2BBBB, 20'h0BBBB, 2'd0, 8'd1, 0, 0, 2'd2, 2'd2, 0);
        probe(1, 32'h2000_0000, 8'd1, 0, 1, 0, 0, "R7 slot0 replaced");
        probe(1, 32'h2000_1000, 8'd1, 0, 1, 0, 0, "R7 slot1 replaced");
        probe(1, 32'h2000_2000, 8'd1, 0, 1, 0, 0, "R7 slot2 kept");
        probe(1, 32'h2AAA_A000, 8'd1, 0, 1, 0, 0, "R7 new A");
        probe(1, 32'h2BBB_B000, 8'd1, 0, 1, 0, 0, "R7 new B");

        // R8: LFSR victim replaces exactly one entry
        do_flush_all();
        victim_rand = 1'b1;
        for (int i = 0; i < N; i++)
            do_fill(20'h60000 + 20'(i), 20'h02000 + 20'(i), 2'd0, 8'd1, 0, 0, 2'd2, 2'd2, 0);
        probe(1, 32'h6001_F000, 8'd1, 0, 1, 0, 0, "R6 random mode free slot");
        do_fill(20'h6CCCC, 20'h0CCCC, 2'd0, 8'd1, 0, 0, 2'd2, 2'd2, 0);
        misses = 0;
        for (int i = 0; i < N; i++) begin
            lk_req = 1; lk_va = {20'h60000 + 20'(i), 12'h0}; lk_asid = 8'd1; lk_ns = 0;
            lk_priv = 1; lk_write = 0; lk_exec = 0;
            #1;
            if (!lk_hit) misses++;
            @(negedge clk);
        end
        chk(misses == 1, "R8 one replaced", 35'(misses), 35'd1);
        lk_va = 32'h6CCC_C000;
        #1;
        chk(lk_hit && lk_pa == 32'h0CCC_C000, "R8 new present", {lk_hit, lk_multi, lk_abort, lk_pa},
            {1'b1, 1'b0, 1'b0, 32'h0CCC_C000});
        @(negedge clk);
        lk_req = 0;
        victim_rand = 1'b0;
        do_flush_all();

        // Random traffic against the reference table, rotating victim mode
        for (int k = 0; k < 4000; k++) begin
            int op = $urandom_range(99);
            logic [19:0] v = {8'h10 + 8'($urandom_range(3)), 4'($urandom_range(3)),
                              4'($urandom_range(3)), 4'($urandom_range(3))};
            if (op < 35) begin
                do_fill(v, 20'($urandom), 2'($urandom_range(3)), 8'($urandom_range(3)),
                        1'($urandom_range(1)), ($urandom_range(7) == 0),
                        2'($urandom_range(3)), 2'($urandom_range(3)), 1'($urandom_range(1)));
            end else if (op < 93) begin
                probe(1, {v, 12'($urandom)}, 8'($urandom_range(3)), 1'($urandom_range(1)),
                      1'($urandom_range(1)), 1'($urandom_range(1)), 1'($urandom_range(1)),
                      "R2 R3 R4 R5 R7 random");
            end else if (op < 98) begin
                do_flush_asid(8'($urandom_range(3)));
            end else begin
                do_flush_all();
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule